// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block derives the serial bit clock and two frame (left/right) clocks for an audio serial port from a single master clock. One 28-bit configuration word sets three 8-bit dividers and four control bits. The bit-clock divider sets the bit rate. The transmit and receive frame dividers count bit periods, each at its own ratio. Three polarity bits invert the outputs. A mode bit hands the three clocks over to external pins. Every divider field holds the divide ratio minus one.

In master mode the dividers run and a glitch-free reload scheme applies new ratios only at frame boundaries. In slave mode the dividers are held at their start state. The three external clocks pass through a two-flop synchroniser and then through the same output registers and polarity inversion.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, all three outputs are driven low at that edge. Every counter restarts at the beginning of a bit period and a frame.
- R2: Field `cfg_word[23:16]` holds M-1, where M is the bit ratio. In master mode `bclk_o` (polarity bit 0) repeats every M master cycles: low for floor(M/2) cycles, then high for the rest.
- R3: A divider field of 0 is treated as a ratio of 2, so no clock runs at the full master rate.
- R4: Field `cfg_word[7:0]` holds F-1 for the transmit frame clock. `tx_lrck_o` is low for floor(F/2) bit periods, then high for the remaining bit periods of each F-bit frame. It changes only at the start of a bit period.
- R5: Field `cfg_word[15:8]` holds F-1 for the receive frame clock. `rx_lrck_o` follows the same rule as R4 with its own ratio, independent of the transmit frame.
- R6: Bit 24 inverts `tx_lrck_o`, bit 25 inverts `rx_lrck_o` and bit 26 inverts `bclk_o`. A value of 0 leaves the clock unchanged. The inversion applies in both modes.
- R7: When bit 27 is 1 (slave), each output equals its external input from three master cycles earlier (two synchroniser flops plus the output register), XOR its polarity bit.
- R8: A new bit or transmit frame ratio takes effect only when a transmit frame completes. A new receive ratio takes effect only when a receive frame completes.
- R9: When bit 27 returns to 0, generation restarts from the beginning of a frame with the current field values. The first transmit frame-clock rise appears floor(F/2)*M+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 28 | Dividers [23:16] bit, [15:8] receive, [7:0] transmit; bit 24/25/26 inversion; bit 27 slave |
| ext_bclk_i | input | 1 | External bit clock (slave) |
| ext_tx_lrck_i | input | 1 | External transmit frame clock (slave) |
| ext_rx_lrck_i | input | 1 | External receive frame clock (slave) |
| bclk_o | output | 1 | Bit clock |
| tx_lrck_o | output | 1 | Transmit frame clock |
| rx_lrck_o | output | 1 | Receive frame clock |

## Verification
The hardest case to reach is a ratio change that lands mid-frame, where the old ratio has to survive until the transmit frame ends. The stimulus waits for the transmit frame clock to rise, so that half a frame remains. It then rewrites the bit ratio and measures one full bit period at the old value. After the frame boundary it measures again at the new value. A second hard case is the exit from slave mode. The stimulus leaves slave mode and counts master cycles to the first generated frame-clock rise, which must match the restart rule.

// File: rtl/audclk_pkg.sv
// Shared widths, channel indices and configuration layout for the
// audio clock generator. Assumes 8-bit divider fields storing ratio-1.
package audclk_pkg;
    localparam int FIELD_W = 8;
    localparam int RATIO_W = FIELD_W + 1;
    localparam int CFG_W   = 3 * FIELD_W + 4;
    localparam int NUM_CH  = 2;
    localparam int CH_TX   = 0;
    localparam int CH_RX   = 1;

    // Configuration word, most significant field first.
    typedef struct packed {
        logic               slave;
        logic               bclk_inv;
        logic               rx_inv;
        logic               tx_inv;
        logic [FIELD_W-1:0] bit_div;
        logic [FIELD_W-1:0] rx_div;
        logic [FIELD_W-1:0] tx_div;
    } audclk_cfg_t;

    // Convert a stored field (ratio-1) into a ratio of at least 2.
    function automatic logic [RATIO_W-1:0] field_to_ratio(input logic [FIELD_W-1:0] f);
        logic [RATIO_W-1:0] r;
        r = {1'b0, f} + 1'b1;
        return (f == '0) ? RATIO_W'(2) : r;
    endfunction
endpackage

// File: rtl/audclk_decode.sv
// Field decode: splits the configuration word into control bits and
// turns each divider field into a clamped ratio. Purely combinational.
module audclk_decode
    import audclk_pkg::*;
(
    input  logic [CFG_W-1:0]              cfg_word,
    output audclk_cfg_t                   cfg,
    output logic [RATIO_W-1:0]            ratio_bit,
    output logic [NUM_CH-1:0][RATIO_W-1:0] ratio_frame
);
    // Map the word onto the structured view and derive ratios.
    always_comb begin
        cfg                = audclk_cfg_t'(cfg_word);
        ratio_bit          = field_to_ratio(cfg.bit_div);
        ratio_frame[CH_TX] = field_to_ratio(cfg.tx_div);
        ratio_frame[CH_RX] = field_to_ratio(cfg.rx_div);
    end
endmodule

// File: rtl/audclk_bitdiv.sv
// Bit-period divider: counts master cycles within one bit period and
// flags its last cycle. Assumes ratio >= 2. Ratio reloads on `reload`.
module audclk_bitdiv #(
    parameter int RATIO_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [RATIO_W-1:0] load_ratio,
    input  logic               reload,
    output logic               bit_end,
    output logic               bclk_lvl
);
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] act;

    // Decode the end of a period and the level of the bit clock.
    always_comb begin
        bit_end  = (cnt == act - 1'b1);
        bclk_lvl = (cnt >= (act >> 1));
    end

    // Advance the cycle counter; take a new ratio only when told to.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= '0;
            act <= load_ratio;
        end else begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
            if (reload) act <= load_ratio;
        end
    end
endmodule

// File: rtl/audclk_framediv.sv
// Frame divider: counts bit periods within a frame and reloads its own
// ratio at the frame end. Assumes ratio >= 2 and one step per bit.
module audclk_framediv #(
    parameter int RATIO_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               step,
    input  logic [RATIO_W-1:0] load_ratio,
    output logic               frame_end,
    output logic               lr_lvl,
    output logic [RATIO_W-1:0] act_ratio
);
    logic [RATIO_W-1:0] cnt;

    // Decode the frame end and the frame-clock level.
    always_comb begin
        frame_end = step && (cnt == act_ratio - 1'b1);
        lr_lvl    = (cnt >= (act_ratio >> 1));
    end

    // Count bit periods and swap the ratio at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt       <= '0;
            act_ratio <= load_ratio;
        end else if (step) begin
            cnt <= frame_end ? '0 : cnt + 1'b1;
            if (frame_end) act_ratio <= load_ratio;
        end
    end
endmodule

// File: rtl/audclk_sync.sv
// Multi-flop synchroniser for the external clock pins. Assumes STAGES>=2
// and that inputs are slow relative to the master clock.
module audclk_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/audio_clkgen.sv
// Top: bit and frame clock generator. Generates clocks locally in master
// mode or forwards synchronised pins in slave mode; applies polarity and
// registers every output. Assumes cfg_word is quasi-static per frame.
module audio_clkgen
    import audclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             ext_bclk_i,
    input  logic             ext_tx_lrck_i,
    input  logic             ext_rx_lrck_i,
    output logic             bclk_o,
    output logic             tx_lrck_o,
    output logic             rx_lrck_o
);
    localparam int PIN_N = NUM_CH + 1;

    audclk_cfg_t                    cfg;
    logic [RATIO_W-1:0]             ratio_bit;
    logic [NUM_CH-1:0][RATIO_W-1:0] ratio_frame;
    logic [NUM_CH-1:0][RATIO_W-1:0] act_f;
    logic [NUM_CH-1:0]              frame_end;
    logic [NUM_CH-1:0]              lr_gen;
    logic [NUM_CH-1:0]              lr_inv;
    logic [NUM_CH-1:0]              lr_q;
    logic [PIN_N-1:0]               pin_sync;
    logic                           bit_end;
    logic                           bclk_gen;

    audclk_decode u_dec (
        .cfg_word    (cfg_word),
        .cfg         (cfg),
        .ratio_bit   (ratio_bit),
        .ratio_frame (ratio_frame)
    );

    audclk_bitdiv #(.RATIO_W(RATIO_W)) u_bdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (cfg.slave),
        .load_ratio (ratio_bit),
        .reload     (frame_end[CH_TX]),
        .bit_end    (bit_end),
        .bclk_lvl   (bclk_gen)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_frame
        audclk_framediv #(.RATIO_W(RATIO_W)) u_fdiv (
            .clk        (clk),
            .rst_n      (rst_n),
            .hold       (cfg.slave),
            .step       (bit_end),
            .load_ratio (ratio_frame[ch]),
            .frame_end  (frame_end[ch]),
            .lr_lvl     (lr_gen[ch]),
            .act_ratio  (act_f[ch])
        );
    end

    audclk_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_rx_lrck_i, ext_tx_lrck_i, ext_bclk_i}),
        .q     (pin_sync)
    );

    assign lr_inv = {cfg.rx_inv, cfg.tx_inv};

    // Select the clock source, apply polarity and register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_o <= 1'b0;
            lr_q   <= '0;
        end else begin
            bclk_o <= (cfg.slave ? pin_sync[0] : bclk_gen) ^ cfg.bclk_inv;
            for (int ch = 0; ch < NUM_CH; ch++)
                lr_q[ch] <= (cfg.slave ? pin_sync[ch+1] : lr_gen[ch]) ^ lr_inv[ch];
        end
    end

    assign tx_lrck_o = lr_q[CH_TX];
    assign rx_lrck_o = lr_q[CH_RX];
endmodule

// File: rtl/audclk_checker.sv
// Assertion checker for audio_clkgen, attached by bind. Observes ports and
// the signals exchanged between the divider submodules.
module audclk_checker
    import audclk_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               slave,
    input logic               bclk_inv,
    input logic               ext_bclk_i,
    input logic               bclk_o,
    input logic               tx_lrck_o,
    input logic               rx_lrck_o,
    input logic               bit_end,
    input logic               bclk_gen,
    input logic               tx_lr_gen,
    input logic               rx_lr_gen,
    input logic               tx_fe,
    input logic               rx_fe,
    input logic [RATIO_W-1:0] act_tx,
    input logic [RATIO_W-1:0] act_rx
);
    logic       past_valid = 1'b0;
    logic [1:0] since_rst;

    // Mark that at least one edge has occurred.
    always_ff @(posedge clk) past_valid <= 1'b1;

    // Count edges out of reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end

    a_r1_reset_low: assert property (@(posedge clk)
        (past_valid && !$past(rst_n)) |-> (!bclk_o && !tx_lrck_o && !rx_lrck_o));

    a_r2_period_starts_low: assert property (@(posedge clk) disable iff (!rst_n || slave)
        bit_end |=> !bclk_gen);

    a_r3_no_single_cycle_bit: assert property (@(posedge clk) disable iff (!rst_n || slave)
        bit_end |=> !bit_end);

    a_r4_tx_frame_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !$past(slave) && tx_lr_gen != $past(tx_lr_gen)) |-> $past(bit_end));

    a_r5_rx_frame_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !$past(slave) && rx_lr_gen != $past(rx_lr_gen)) |-> $past(bit_end));

    a_r5_rx_end_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fe || tx_fe) |-> bit_end);

    a_r7_slave_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(slave)) |-> (bclk_o == ($past(ext_bclk_i, 3) ^ $past(bclk_inv))));

    a_r8_tx_reload_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !$past(slave) && act_tx != $past(act_tx)) |-> $past(tx_fe));

    a_r8_rx_reload_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !$past(slave) && act_rx != $past(act_rx)) |-> $past(rx_fe));
endmodule

bind audio_clkgen audclk_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave      (cfg.slave),
    .bclk_inv   (cfg.bclk_inv),
    .ext_bclk_i (ext_bclk_i),
    .bclk_o     (bclk_o),
    .tx_lrck_o  (tx_lrck_o),
    .rx_lrck_o  (rx_lrck_o),
    .bit_end    (bit_end),
    .bclk_gen   (bclk_gen),
    .tx_lr_gen  (lr_gen[0]),
    .rx_lr_gen  (lr_gen[1]),
    .tx_fe      (frame_end[0]),
    .rx_fe      (frame_end[1]),
    .act_tx     (act_f[0]),
    .act_rx     (act_f[1])
);

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] cfg_word = '0;
    logic        ext_b = 1'b0, ext_t = 1'b0, ext_r = 1'b0;
    logic        bclk_o, tx_lrck_o, rx_lrck_o;

    int n_chk = 0, n_bad = 0, cycles = 0;
    bit cmp_on = 0;

    always #2 clk = ~clk;

    audio_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .ext_bclk_i(ext_b), .ext_tx_lrck_i(ext_t), .ext_rx_lrck_i(ext_r),
        .bclk_o(bclk_o), .tx_lrck_o(tx_lrck_o), .rx_lrck_o(rx_lrck_o)
    );

    function automatic logic [27:0] mk(input bit slv, input bit binv, input bit rinv,
                                       input bit tinv, input int m, input int r, input int t);
        return {slv, binv, rinv, tinv, 8'(m), 8'(r), 8'(t)};
    endfunction

    function automatic int ratio(input int f);
        return (f == 0) ? 2 : f + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_cnt, m_act, f_cnt[2], f_act[2];
    bit s1[3], s2[3];
    bit e_b = 0, e_t = 0, e_r = 0;
    always @(posedge clk) begin
        bit gb, gt, gr, slv, be, fe0, fe1;
        if (!rst_n) begin
            e_b = 0; e_t = 0; e_r = 0;
            s1 = '{0, 0, 0}; s2 = '{0, 0, 0};
            m_cnt = 0; f_cnt = '{0, 0};
            m_act = ratio(cfg_word[23:16]); f_act[0] = ratio(cfg_word[7:0]); f_act[1] = ratio(cfg_word[15:8]);
        end else begin
            gb  = m_cnt >= m_act / 2;
            gt  = f_cnt[0] >= f_act[0] / 2;
            gr  = f_cnt[1] >= f_act[1] / 2;
            slv = cfg_word[27];
            e_b = (slv ? s2[0] : gb) ^ cfg_word[26];
            e_t = (slv ? s2[1] : gt) ^ cfg_word[24];
            e_r = (slv ? s2[2] : gr) ^ cfg_word[25];
            s2 = s1; s1 = '{ext_b, ext_t, ext_r};
            if (slv) begin
                m_cnt = 0; f_cnt = '{0, 0};
                m_act = ratio(cfg_word[23:16]); f_act[0] = ratio(cfg_word[7:0]); f_act[1] = ratio(cfg_word[15:8]);
            end else begin
                be  = (m_cnt == m_act - 1);
                fe0 = be && (f_cnt[0] == f_act[0] - 1);
                fe1 = be && (f_cnt[1] == f_act[1] - 1);
                m_cnt = be ? 0 : m_cnt + 1;
                if (be) begin
                    f_cnt[0] = fe0 ? 0 : f_cnt[0] + 1;
                    f_cnt[1] = fe1 ? 0 : f_cnt[1] + 1;
                end
                if (fe0) begin m_act = ratio(cfg_word[23:16]); f_act[0] = ratio(cfg_word[7:0]); end
                if (fe1) f_act[1] = ratio(cfg_word[15:8]);
            end
        end
    end

    // Per-clock comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cfg_word[27] ? "R7 bclk" : "R2 bclk", int'(bclk_o), int'(e_b));
            chk(cfg_word[27] ? "R7 tx"   : "R4 tx",   int'(tx_lrck_o), int'(e_t));
            chk(cfg_word[27] ? "R7 rx"   : "R5 rx",   int'(rx_lrck_o), int'(e_r));
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit get(input int sel);
        return (sel == 0) ? bclk_o : (sel == 1) ? tx_lrck_o : rx_lrck_o;
    endfunction

    // Measure high length and full period (master cycles) from a rising edge.
    task automatic meas(input int sel, output int hi, output int per);
        int lo;
        while (get(sel) == 1'b1) tick();
        while (get(sel) == 1'b0) tick();
        hi = 1; tick();
        while (get(sel) == 1'b1) begin hi++; tick(); end
        lo = 1; tick();
        while (get(sel) == 1'b0) begin lo++; tick(); end
        per = hi + lo;
    endtask

    initial begin
        int hi, per, n;
        cfg_word = mk(0, 0, 0, 0, 3, 4, 7);
        tick(4);
        chk("R1 reset bclk", int'(bclk_o), 0);
        chk("R1 reset tx", int'(tx_lrck_o), 0);
        chk("R1 reset rx", int'(rx_lrck_o), 0);
        cmp_on = 1;
        rst_n = 1'b1;

        meas(0, hi, per); chk("R2 bclk period", per, 4); chk("R2 bclk high", hi, 2);
        meas(1, hi, per); chk("R4 tx period", per, 32); chk("R4 tx high", hi, 16);
        meas(2, hi, per); chk("R5 rx period", per, 20); chk("R5 rx high", hi, 12);

        // R8: change the bit ratio mid-frame; old ratio must persist.
        while (tx_lrck_o == 1'b1) tick();
        while (tx_lrck_o == 1'b0) tick();
        cfg_word = mk(0, 0, 0, 0, 9, 4, 7);
        meas(0, hi, per); chk("R8 old ratio kept", per, 4);
        tick(80);
        meas(0, hi, per); chk("R8 new ratio period", per, 10); chk("R8 new ratio high", hi, 5);

        // R3: zero fields behave as ratio 2.
        cfg_word = mk(0, 0, 0, 0, 0, 4, 0);
        tick(120);
        meas(0, hi, per); chk("R3 bclk min period", per, 2);
        meas(1, hi, per); chk("R3 tx min period", per, 4);

        // R6: inversion of bit clock and transmit frame clock.
        cfg_word = mk(0, 1, 0, 1, 4, 4, 7);
        tick(200);
        meas(0, hi, per); chk("R6 bclk inverted high", hi, 2); chk("R6 bclk period", per, 5);
        meas(1, hi, per); chk("R6 tx inverted high", hi, 20);

        // R7: slave mode forwards pins after the synchroniser.
        cfg_word = mk(1, 0, 0, 0, 3, 4, 7);
        ext_b = 1; ext_t = 0; ext_r = 1;
        tick(4);
        chk("R7 slave bclk", int'(bclk_o), 1);
        chk("R7 slave tx", int'(tx_lrck_o), 0);
        chk("R7 slave rx", int'(rx_lrck_o), 1);
        for (int i = 0; i < 60; i++) begin
            ext_b = ~ext_b;
            if (i % 3 == 0) ext_t = ~ext_t;
            if (i % 5 == 1) ext_r = ~ext_r;
            tick();
        end
        cfg_word = mk(1, 1, 1, 1, 3, 4, 7);
        ext_b = 1; ext_t = 1; ext_r = 0;
        tick(4);
        chk("R7 slave bclk inverted", int'(bclk_o), 0);
        chk("R7 slave tx inverted", int'(tx_lrck_o), 0);
        chk("R7 slave rx inverted", int'(rx_lrck_o), 1);

        // R9: leaving slave restarts the frame from its start.
        ext_b = 0; ext_t = 0; ext_r = 0;
        cfg_word = mk(1, 0, 0, 0, 3, 4, 7);
        tick(4);
        cfg_word = mk(0, 0, 0, 0, 3, 4, 7);
        n = 0;
        do begin tick(); n++; end while (tx_lrck_o == 1'b0 && n < 100);
        chk("R9 first tx rise", n, 17);

        // R1: reset in the middle of operation.
        tick(7);
        rst_n = 1'b0;
        tick(2);
        chk("R1 mid reset bclk", int'(bclk_o), 0);
        chk("R1 mid reset tx", int'(tx_lrck_o), 0);
        chk("R1 mid reset rx", int'(rx_lrck_o), 0);
        rst_n = 1'b1;
        tick(50);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule